// File: doc/BRIEF.md
# Bit-Plane SIMD Processor Array

This block is a square grid of one-bit processing elements that all obey a single instruction stream. Each element keeps a one-bit accumulator, a one-bit activity flag and a private column of bits across a small set of local planes. A plane is one bit per element, so one instruction acts on a whole N×N plane at once. Element (r, c) sits at bit r*N + c of every plane vector. Row 0 is the north edge and column 0 is the west edge.

A control unit issues instructions made of an opcode, a source plane, a destination plane, an index and a wrap bit. The block can do element-wise Boolean operations and move the accumulator plane one step across the 4-neighbour mesh. Row and column data paths let it replicate one row or one column over the whole plane, or fold each row or column into an N-bit vector. A bit-serial search runs over several planes and finds, per row or per column, the elements that hold the maximum. The activity flags gate every accumulator and plane update. A host port writes and reads planes one row at a time.

Top module: `bpa_array`

## Requirements
- R1: After reset the accumulator plane and the reduction vector are all zero, every activity flag is one, and `busy` and `done` are low.
- R2: Opcode encodings: 0 no-op, 1 load, 2 store, 3 AND, 4 OR, 5 XOR, 6 NOT, 7 set activity, 8 shift, 9 row broadcast, 10 column broadcast, 11 row OR reduce, 12 column OR reduce, 13 row maximum, 14 column maximum, 15 activate all. An instruction is accepted on a clock edge where `ins_valid` is high and `busy` is low. Every opcode except 13 and 14 completes at that edge, and `done` is high for the following cycle. Load copies the source plane into the accumulator. AND, OR and XOR combine the accumulator with the source plane. NOT inverts the accumulator.
- R3: Set activity copies the source plane into the activity flags and is not masked. Activate all sets every flag. Load, the logic operations, shift and broadcast change only active accumulator bits. Store and the maximum result write only active bits of the destination plane.
- R4: Shift moves the accumulator one step. The direction comes from `ins_idx[1:0]`: 0 north (element (r,c) takes (r+1,c)), 1 east (takes (r,c-1)), 2 south (takes (r-1,c)), 3 west (takes (r,c+1)). With `ins_wrap` low, the bit shifted in at the edge is zero.
- R5: With `ins_wrap` high, shifts wrap around the edges, so the mesh acts as a torus.
- R6: Row broadcast writes row `ins_idx` of the source plane into every row of the accumulator. Column broadcast writes column `ins_idx` into every column.
- R7: Row OR reduce sets `rvec_o[i]` to the OR of the active elements of row i of the source plane. Column OR reduce does the same over column i. `rvec_o` changes only on these two operations.
- R8: The maximum search takes k = `ins_idx`+1 planes, with the most significant at `ins_src` and each next one an address lower (modulo the plane count). It starts from the active set as candidates. At each plane, a row (or column) in which some candidate has a one keeps only those candidates. `busy` stays high for k cycles, and the final candidates are written to `ins_dst`. Instructions presented while `busy` is high are ignored.
- R9: `host_we` writes `host_wdata` into row `host_row` of plane `host_plane` at the clock edge. `host_rdata` shows that row combinationally. When a host write and an instruction write hit the same plane in one cycle, the host row wins and the other rows take the instruction write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present |
| ins_op | input | 4 | Opcode |
| ins_src | input | $clog2(PLANES) | Source plane address |
| ins_dst | input | $clog2(PLANES) | Destination plane address |
| ins_idx | input | $clog2(N) | Row/column index, shift direction or maximum length minus one |
| ins_wrap | input | 1 | Toroidal shift select |
| busy | output | 1 | Multi-cycle maximum in progress |
| done | output | 1 | Instruction completed in the previous edge |
| host_we | input | 1 | Host row write |
| host_plane | input | $clog2(PLANES) | Host plane address |
| host_row | input | $clog2(N) | Host row address |
| host_wdata | input | N | Host write row |
| host_rdata | output | N | Host read row |
| acc_o | output | N*N | Accumulator plane |
| rvec_o | output | N | Reduction vector |

## Verification
Two writes can reach the plane store in the same cycle: a store instruction (or the final write of a maximum search) and a host row write aimed at the same plane. The bench drives both on one clock edge, then reads every row of that plane back. The chosen row must hold the host data, and the other rows must hold the accumulator merged under the activity mask. A second overlap is an instruction presented while a maximum search is busy. The bench checks that it leaves the accumulator untouched.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_STORE  = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_NOT    = 4'd6,
    OP_SETACT = 4'd7,
    OP_SHIFT  = 4'd8,
    OP_RBC    = 4'd9,
    OP_CBC    = 4'd10,
    OP_RRED   = 4'd11,
    OP_CRED   = 4'd12,
    OP_RMAX   = 4'd13,
    OP_CMAX   = 4'd14,
    OP_ALLACT = 4'd15
  } bpa_op_e;

  localparam logic [1:0] DIR_N = 2'd0;
  localparam logic [1:0] DIR_E = 2'd1;
  localparam logic [1:0] DIR_S = 2'd2;
  localparam logic [1:0] DIR_W = 2'd3;
endpackage

// File: rtl/bpa_plane_store.sv
module bpa_plane_store #(
  parameter int N      = 8,
  parameter int PLANES = 8,
  localparam int NN    = N * N,
  localparam int PW    = $clog2(PLANES),
  localparam int IW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [NN-1:0] wr_data,
  input  logic [NN-1:0] wr_mask,
  input  logic          host_we,
  input  logic [PW-1:0] host_plane,
  input  logic [IW-1:0] host_row,
  input  logic [N-1:0]  host_wdata,
  input  logic [PW-1:0] rd_addr,
  output logic [NN-1:0] rd_data,
  output logic [N-1:0]  host_rdata
);
  logic [NN-1:0] mem_q [PLANES];
  logic [NN-1:0] mem_d [PLANES];
  logic [PLANES-1:0] pl_en;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic ins_hit, host_hit;
    assign ins_hit  = wr_en && (wr_addr == PW'(p));
    assign host_hit = host_we && (host_plane == PW'(p));
    assign pl_en[p] = ins_hit || host_hit;

    always_comb begin
      mem_d[p] = mem_q[p];
      if (ins_hit) mem_d[p] = (mem_q[p] & ~wr_mask) | (wr_data & wr_mask);
      if (host_hit) mem_d[p][int'(host_row)*N +: N] = host_wdata;
    end

    always_ff @(posedge clk) begin
      if (pl_en[p]) mem_q[p] <= mem_d[p];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
      p_host_row_wins_r9: assert property (@(posedge clk) disable iff (!rst_i)
        (host_we && host_plane == PW'(p) && host_row == IW'(r))
        |=> mem_q[p][r*N +: N] == $past(host_wdata));
    end
  end

  always_comb begin
    rd_data    = mem_q[rd_addr];
    host_rdata = mem_q[host_plane][int'(host_row)*N +: N];
  end
endmodule

// File: rtl/bpa_route.sv
module bpa_route #(
  parameter int N   = 8,
  localparam int NN = N * N,
  localparam int IW = $clog2(N)
) (
  input  logic [NN-1:0] acc,
  input  logic [NN-1:0] plane,
  input  logic [IW-1:0] idx,
  input  logic          wrap,
  output logic [NN-1:0] shift_o,
  output logic [NN-1:0] rbc_o,
  output logic [NN-1:0] cbc_o
);
  import bpa_pkg::*;

  logic [1:0] dir;
  assign dir = idx[1:0];

  always_comb begin
    shift_o = '0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        int  sr;
        int  sc;
        logic inb;
        sr = r;
        sc = c;
        case (dir)
          DIR_N:   sr = r + 1;
          DIR_E:   sc = c - 1;
          DIR_S:   sr = r - 1;
          default: sc = c + 1;
        endcase
        inb = (sr >= 0) && (sr < N) && (sc >= 0) && (sc < N);
        if (inb || wrap)
          shift_o[r*N+c] = acc[((sr + N) % N) * N + ((sc + N) % N)];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        rbc_o[r*N+c] = plane[int'(idx)*N + c];
        cbc_o[r*N+c] = plane[r*N + int'(idx)];
      end
    end
  end
endmodule

// File: rtl/bpa_reduce.sv
module bpa_reduce #(
  parameter int N   = 8,
  localparam int NN = N * N
) (
  input  logic [NN-1:0] plane,
  input  logic [NN-1:0] act,
  input  logic [NN-1:0] cand,
  input  logic          col_mode,
  output logic [N-1:0]  or_vec,
  output logic [NN-1:0] cand_nxt
);
  logic [N-1:0] any_grp;

  always_comb begin
    or_vec  = '0;
    any_grp = '0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        or_vec[col_mode ? c : r]  |= plane[r*N+c] & act[r*N+c];
        any_grp[col_mode ? c : r] |= plane[r*N+c] & cand[r*N+c];
      end
    end
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        cand_nxt[r*N+c] = any_grp[col_mode ? c : r] ? (cand[r*N+c] & plane[r*N+c])
                                                     : cand[r*N+c];
      end
    end
  end
endmodule

// File: rtl/bpa_array.sv
module bpa_array #(
  parameter int N      = 8,
  parameter int PLANES = 8,
  localparam int NN    = N * N,
  localparam int PW    = $clog2(PLANES),
  localparam int IW    = $clog2(N),
  localparam int LW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [3:0]    ins_op,
  input  logic [PW-1:0] ins_src,
  input  logic [PW-1:0] ins_dst,
  input  logic [IW-1:0] ins_idx,
  input  logic          ins_wrap,
  output logic          busy,
  output logic          done,
  input  logic          host_we,
  input  logic [PW-1:0] host_plane,
  input  logic [IW-1:0] host_row,
  input  logic [N-1:0]  host_wdata,
  output logic [N-1:0]  host_rdata,
  output logic [NN-1:0] acc_o,
  output logic [N-1:0]  rvec_o
);
  import bpa_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [NN-1:0] acc_q, acc_d, act_q, act_d, cand_q, cand_d;
  logic [N-1:0]  rvec_q, rvec_d;
  logic          busy_q, busy_d, done_q, done_d, mcol_q, mcol_d;
  logic [PW-1:0] ptr_q, ptr_d, mdst_q, mdst_d;
  logic [LW-1:0] left_q, left_d;

  bpa_op_e       op;
  logic          accept, is_max, is_red;
  logic          wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [NN-1:0] wr_data, rd_data;
  logic [NN-1:0] shift_pl, rbc_pl, cbc_pl, cand_step;
  logic [N-1:0]  or_vec;
  logic          red_col;

  assign op     = bpa_op_e'(ins_op);
  assign accept = ins_valid && !busy_q;
  assign is_max = (op == OP_RMAX) || (op == OP_CMAX);
  assign is_red = (op == OP_RRED) || (op == OP_CRED);

  assign rd_addr = busy_q ? ptr_q : ins_src;
  assign red_col = busy_q ? mcol_q : (op == OP_CRED);

  bpa_plane_store #(.N(N), .PLANES(PLANES)) u_store (
    .clk(clk), .rst_i(rst_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(act_q),
    .host_we(host_we), .host_plane(host_plane), .host_row(host_row),
    .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .host_rdata(host_rdata)
  );

  bpa_route #(.N(N)) u_route (
    .acc(acc_q), .plane(rd_data), .idx(ins_idx), .wrap(ins_wrap),
    .shift_o(shift_pl), .rbc_o(rbc_pl), .cbc_o(cbc_pl)
  );

  bpa_reduce #(.N(N)) u_reduce (
    .plane(rd_data), .act(act_q), .cand(cand_q), .col_mode(red_col),
    .or_vec(or_vec), .cand_nxt(cand_step)
  );

  function automatic logic [NN-1:0] merge(input logic [NN-1:0] old_v,
                                          input logic [NN-1:0] new_v,
                                          input logic [NN-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  // next-state
  always_comb begin
    acc_d   = acc_q;
    act_d   = act_q;
    rvec_d  = rvec_q;
    cand_d  = cand_q;
    busy_d  = busy_q;
    mcol_d  = mcol_q;
    ptr_d   = ptr_q;
    mdst_d  = mdst_q;
    left_d  = left_q;
    done_d  = 1'b0;
    wr_en   = 1'b0;
    wr_addr = ins_dst;
    wr_data = acc_q;
    if (busy_q) begin
      cand_d = cand_step;
      ptr_d  = ptr_q - PW'(1);
      left_d = left_q - LW'(1);
      if (left_q == LW'(1)) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        wr_en   = 1'b1;
        wr_addr = mdst_q;
        wr_data = cand_step;
      end
    end else if (accept) begin
      done_d = !is_max;
      case (op)
        OP_LOAD:   acc_d = merge(acc_q, rd_data, act_q);
        OP_STORE:  wr_en = 1'b1;
        OP_AND:    acc_d = merge(acc_q, acc_q & rd_data, act_q);
        OP_OR:     acc_d = merge(acc_q, acc_q | rd_data, act_q);
        OP_XOR:    acc_d = merge(acc_q, acc_q ^ rd_data, act_q);
        OP_NOT:    acc_d = merge(acc_q, ~acc_q, act_q);
        OP_SETACT: act_d = rd_data;
        OP_SHIFT:  acc_d = merge(acc_q, shift_pl, act_q);
        OP_RBC:    acc_d = merge(acc_q, rbc_pl, act_q);
        OP_CBC:    acc_d = merge(acc_q, cbc_pl, act_q);
        OP_RRED, OP_CRED: rvec_d = or_vec;
        OP_RMAX, OP_CMAX: begin
          busy_d = 1'b1;
          cand_d = act_q;
          ptr_d  = ins_src;
          mdst_d = ins_dst;
          mcol_d = (op == OP_CMAX);
          left_d = LW'(ins_idx) + LW'(1);
        end
        OP_ALLACT: act_d = '1;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      acc_q  <= '0;
      act_q  <= '1;
      rvec_q <= '0;
      cand_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mcol_q <= 1'b0;
      ptr_q  <= '0;
      mdst_q <= '0;
      left_q <= '0;
    end else begin
      acc_q  <= acc_d;
      act_q  <= act_d;
      rvec_q <= rvec_d;
      cand_q <= cand_d;
      busy_q <= busy_d;
      done_q <= done_d;
      mcol_q <= mcol_d;
      ptr_q  <= ptr_d;
      mdst_q <= mdst_d;
      left_q <= left_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign acc_o  = acc_q;
  assign rvec_o = rvec_q;

  p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (accept && !is_max) |=> done_q);

  p_acc_masked_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (accept || busy_q) |=> ((acc_q ^ $past(acc_q)) & ~$past(act_q)) == '0);

  p_rvec_hold_r7: assert property (@(posedge clk) disable iff (!rst_i)
    !(accept && is_red) |=> $stable(rvec_q));

  p_busy_no_done_r8: assert property (@(posedge clk) disable iff (!rst_i)
    busy_q |-> !done_q);

  p_max_keeps_busy_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (busy_q && left_q != LW'(1)) |=> busy_q);

  p_busy_acc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_i)
    busy_q |=> $stable(acc_q));
endmodule

// File: tb/test_bpa_array.sv
module test_bpa_array;
  localparam int N  = 8;
  localparam int P  = 8;
  localparam int NN = N * N;
  localparam int NV = 24;

  // vector fields: op[13:10] src[9:7] dst[6:4] idx[3:1] wrap[0]
  localparam logic [13:0] VEC [NV] = '{
    {4'd1, 3'd0, 3'd0, 3'd0, 1'b0},
    {4'd3, 3'd1, 3'd0, 3'd0, 1'b0},
    {4'd4, 3'd2, 3'd0, 3'd0, 1'b0},
    {4'd5, 3'd3, 3'd0, 3'd0, 1'b0},
    {4'd6, 3'd0, 3'd0, 3'd0, 1'b0},
    {4'd2, 3'd0, 3'd4, 3'd0, 1'b0},
    {4'd8, 3'd0, 3'd0, 3'd0, 1'b0},
    {4'd8, 3'd0, 3'd0, 3'd1, 1'b1},
    {4'd8, 3'd0, 3'd0, 3'd2, 1'b0},
    {4'd8, 3'd0, 3'd0, 3'd3, 1'b1},
    {4'd9, 3'd1, 3'd0, 3'd5, 1'b0},
    {4'd10, 3'd2, 3'd0, 3'd0, 1'b0},
    {4'd11, 3'd3, 3'd0, 3'd0, 1'b0},
    {4'd12, 3'd5, 3'd0, 3'd0, 1'b0},
    {4'd7, 3'd6, 3'd0, 3'd0, 1'b0},
    {4'd1, 3'd5, 3'd0, 3'd0, 1'b0},
    {4'd8, 3'd0, 3'd0, 3'd0, 1'b1},
    {4'd2, 3'd0, 3'd7, 3'd0, 1'b0},
    {4'd11, 3'd1, 3'd0, 3'd0, 1'b0},
    {4'd13, 3'd2, 3'd6, 3'd2, 1'b0},
    {4'd14, 3'd7, 3'd5, 3'd0, 1'b0},
    {4'd15, 3'd0, 3'd0, 3'd0, 1'b0},
    {4'd13, 3'd7, 3'd3, 3'd7, 1'b0},
    {4'd12, 3'd3, 3'd0, 3'd0, 1'b0}
  };

  logic          clk, rst_n;
  logic          ins_valid, ins_wrap, host_we;
  logic [3:0]    ins_op;
  logic [2:0]    ins_src, ins_dst, ins_idx, host_plane, host_row;
  logic [N-1:0]  host_wdata, host_rdata, rvec_o;
  logic [NN-1:0] acc_o;
  logic          busy, done;

  bpa_array #(.N(N), .PLANES(P)) i_bpa_array (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_src(ins_src), .ins_dst(ins_dst), .ins_idx(ins_idx), .ins_wrap(ins_wrap),
    .busy(busy), .done(done), .host_we(host_we), .host_plane(host_plane),
    .host_row(host_row), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .acc_o(acc_o), .rvec_o(rvec_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit [NN-1:0] m_mem [P];
  bit [NN-1:0] m_acc, m_act;
  bit [N-1:0]  m_rvec;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog R8: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [NN-1:0] act_v,
                       input logic [NN-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic wrap);
    case (op)
      4'd7, 4'd15: return "R3";
      4'd8:        return wrap ? "R5" : "R4";
      4'd9, 4'd10: return "R6";
      4'd11, 4'd12: return "R7";
      4'd13, 4'd14: return "R8";
      default:     return "R2";
    endcase
  endfunction

  // element (r,c) of the moved plane receives what sat one step against the direction
  function automatic bit [NN-1:0] m_shift(input bit [NN-1:0] a, input int dir, input bit wrap);
    bit [NN-1:0] o = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int tr = r, tc = c;
        if (dir == 0) tr = r - 1;
        if (dir == 1) tc = c + 1;
        if (dir == 2) tr = r + 1;
        if (dir == 3) tc = c - 1;
        if (tr >= 0 && tr < N && tc >= 0 && tc < N) o[tr*N+tc] = a[r*N+c];
        else if (wrap) o[((tr+N)%N)*N + (tc+N)%N] = a[r*N+c];
      end
    return o;
  endfunction

  function automatic bit [NN-1:0] mg(input bit [NN-1:0] o, input bit [NN-1:0] n);
    return (o & ~m_act) | (n & m_act);
  endfunction

  task automatic m_exec(input logic [13:0] v);
    int op = v[13:10], s = v[9:7], d = v[6:4], ix = v[3:1];
    bit w = v[0];
    bit [NN-1:0] t;
    case (op)
      1: m_acc = mg(m_acc, m_mem[s]);
      2: m_mem[d] = mg(m_mem[d], m_acc);
      3: m_acc = mg(m_acc, m_acc & m_mem[s]);
      4: m_acc = mg(m_acc, m_acc | m_mem[s]);
      5: m_acc = mg(m_acc, m_acc ^ m_mem[s]);
      6: m_acc = mg(m_acc, ~m_acc);
      7: m_act = m_mem[s];
      8: m_acc = mg(m_acc, m_shift(m_acc, ix % 4, w));
      9, 10: begin
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++)
            t[r*N+c] = (op == 9) ? m_mem[s][ix*N+c] : m_mem[s][r*N+ix];
        m_acc = mg(m_acc, t);
      end
      11, 12: for (int g = 0; g < N; g++) begin
        m_rvec[g] = 1'b0;
        for (int k = 0; k < N; k++) begin
          int e = (op == 11) ? g*N+k : k*N+g;
          m_rvec[g] |= m_mem[s][e] & m_act[e];
        end
      end
      13, 14: begin
        bit [NN-1:0] cnd = m_act;
        for (int j = 0; j <= ix; j++) begin
          bit [NN-1:0] pl = m_mem[(s - j + P) % P];
          for (int g = 0; g < N; g++) begin
            bit hit = 1'b0;
            for (int k = 0; k < N; k++) begin
              int e = (op == 13) ? g*N+k : k*N+g;
              hit |= cnd[e] & pl[e];
            end
            if (hit)
              for (int k = 0; k < N; k++) begin
                int e = (op == 13) ? g*N+k : k*N+g;
                cnd[e] = cnd[e] & pl[e];
              end
          end
        end
        m_mem[d] = mg(m_mem[d], cnd);
      end
      15: m_act = '1;
      default: ;
    endcase
  endtask

  task automatic drive(input logic [13:0] v);
    ins_valid = 1'b1;
    ins_op = v[13:10]; ins_src = v[9:7]; ins_dst = v[6:4];
    ins_idx = v[3:1]; ins_wrap = v[0];
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic issue(input logic [13:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    wait_done();
    m_exec(v);
    check(tag_of(v[13:10], v[0]), acc_o, m_acc);
    check("R7 rvec", NN'(rvec_o), NN'(m_rvec));
  endtask

  task automatic check_plane(input int p, input string tag);
    for (int r = 0; r < N; r++) begin
      host_plane = 3'(p); host_row = 3'(r);
      #1;
      check(tag, NN'(host_rdata), NN'(m_mem[p][r*N +: N]));
    end
  endtask

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_op = '0; ins_src = '0; ins_dst = '0;
    ins_idx = '0; ins_wrap = 1'b0; host_we = 1'b0; host_plane = '0;
    host_row = '0; host_wdata = '0;
    m_acc = '0; m_act = '1; m_rvec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 acc", acc_o, '0);
    check("R1 rvec", NN'(rvec_o), '0);
    check("R1 busy/done", NN'({busy, done}), '0);

    // R9 host load of every plane, then read back
    for (int p = 0; p < P; p++)
      for (int r = 0; r < N; r++) begin
        host_we = 1'b1; host_plane = 3'(p); host_row = 3'(r);
        host_wdata = N'(p*53 + r*29 + 7 + p*r*3);
        m_mem[p][r*N +: N] = host_wdata;
        @(negedge clk);
      end
    host_we = 1'b0;
    check_plane(2, "R9 host rw");

    // table walk
    for (int i = 0; i < NV; i++) issue(VEC[i]);
    for (int p = 0; p < P; p++) check_plane(p, "R3 plane contents");

    // R8: instruction during busy is ignored
    begin
      logic [13:0] mx = {4'd14, 3'd6, 3'd1, 3'd3, 1'b0};
      drive(mx);
      @(posedge clk);
      @(negedge clk);
      check("R8 busy", NN'(busy), NN'(1));
      drive({4'd6, 3'd0, 3'd0, 3'd0, 1'b0});
      @(negedge clk);
      ins_valid = 1'b0;
      wait_done();
      m_exec(mx);
      check("R8 ignored while busy", acc_o, m_acc);
      check_plane(1, "R8 column max");
    end

    // R9: store and host row write to the same plane in one cycle
    drive({4'd2, 3'd0, 3'd2, 3'd0, 1'b0});
    host_we = 1'b1; host_plane = 3'd2; host_row = 3'd3; host_wdata = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0; host_we = 1'b0;
    m_exec({4'd2, 3'd0, 3'd2, 3'd0, 1'b0});
    m_mem[2][3*N +: N] = 8'hA5;
    check_plane(2, "R9 collision");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule